// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides which of four on-chip interrupt causes an 8-bit microcontroller core services next. The causes are the overflow of timer 0, the overflow of timer 1, the serial port (receive or transmit done) and timer 2. Every cycle in which it is idle, it reads the enable byte, the priority byte, the three control bytes that carry the request flags, the current program counter and the stack pointer. It then picks at most one request.

An accepted request starts a two-cycle sequence on a byte-wide data-memory write port. The first cycle writes the low byte of the program counter above the stack pointer. The second cycle writes the high byte, stores the advanced stack pointer and loads the fixed vector into the program counter. Two levels of nesting are tracked: a high-priority service may interrupt a low-priority one, but not the other way round. A return strobe from the core steps the active level back down.

Top module: `ivc_ctrl`

## Requirements
- R1: No request is accepted while bit 7 of `ien_i` (global enable) is 0.
- R2: A source takes part only if its enable bit in `ien_i` is 1: bit 1 for timer 0, bit 3 for timer 1, bit 4 for serial, bit 5 for timer 2. The bit at the same position in `ipri_i` selects the high level (1) or the low level (0).
- R3: High-level requests are considered before low-level ones. A level is considered only if it is strictly above the active level. Encodings on `act_lvl_o`: 0 = none, 1 = low, 2 = high.
- R4: Within one level, the sources are ranked timer 0, timer 1, serial, timer 2. Only the first pending source is accepted per evaluation.
- R5: The request conditions are:
  - timer 0 when `tctl_i` bit 5 is 1;
  - timer 1 when `tctl_i` bit 7 is 1;
  - serial when `sctl_i` bit 0 or bit 1 is 1;
  - timer 2 when `t2ctl_i` bit 7 is 1.
  
  All other bits of these inputs have no effect.
- R6: The vector on `vec_addr_o` is 0x000B for timer 0, 0x001B for timer 1, 0x0023 for serial and 0x002B for timer 2.
- R7: The push runs over two cycles.
  - In the first cycle after acceptance, the port writes PC[7:0] to address SP+1.
  - In the next cycle, it writes PC[15:8] to SP+2. In that same cycle, `sp_wr_o` and `vec_ld_o` are high and `sp_val_o` is SP+2.
  
  All address arithmetic wraps modulo 256. PC and SP are the values sampled at acceptance.
- R8: `clr_tf0_o` or `clr_tf1_o` pulses in the first push cycle when timer 0 or timer 1 is accepted, respectively. No clear pulse is issued for serial or timer 2.
- R9: From the first push cycle on, `act_lvl_o` shows the level of the accepted request.
- R10: A `ret_i` pulse while idle steps the active level back one step: high to low if a low service was interrupted, otherwise to none. It has no effect when the level is none or while busy. No request is accepted in a cycle with `ret_i` high.
- R11: `busy_o` is high during the two push cycles. No new request is evaluated until it falls.
- R12: During and after reset, `busy_o`, `wr_en_o`, `sp_wr_o` and `vec_ld_o` are 0 and `act_lvl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien_i | input | 8 | Enable byte (global and per-source enables) |
| ipri_i | input | 8 | Priority byte (per-source level select) |
| tctl_i | input | 8 | Timer control byte carrying both timer overflow flags |
| sctl_i | input | 8 | Serial control byte carrying the two serial flags |
| t2ctl_i | input | 8 | Timer-2 control byte carrying its flag |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 8 | Current stack pointer |
| ret_i | input | 1 | Return-from-service strobe |
| busy_o | output | 1 | Push sequence in progress |
| act_lvl_o | output | 2 | Active service level |
| wr_en_o | output | 1 | Data memory write enable |
| wr_addr_o | output | 8 | Data memory write address |
| wr_data_o | output | 8 | Data memory write byte |
| sp_wr_o | output | 1 | Stack pointer store strobe |
| sp_val_o | output | 8 | New stack pointer value |
| vec_ld_o | output | 1 | Program counter vector load strobe |
| vec_addr_o | output | 16 | Vector address |
| clr_tf0_o | output | 1 | Clear strobe for the timer 0 overflow flag |
| clr_tf1_o | output | 1 | Clear strobe for the timer 1 overflow flag |

## Verification
The assertions assume the flag bytes come from a register that acts on the clear strobes or on software. A request therefore does not have to stay raised once it is accepted. The assertions also assume `ret_i` is a single-cycle pulse that the core only issues after a service has started. The stimulus follows these assumptions. It drops every request flag in the first push cycle, and it raises `ret_i` only after a service completes, except in one deliberate pulse during a push. The unused bits of the flag, enable and priority bytes are filled with a counter pattern, so that only the meaningful positions decide the outcome.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int BYTE_W  = 8;
    localparam int PC_W    = 16;
    localparam int NSRC    = 4;
    localparam int SRC_W   = $clog2(NSRC);
    localparam int GIE_BIT = 7;
    localparam int TF0_BIT = 5;
    localparam int TF1_BIT = 7;
    localparam int T2F_BIT = 7;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2
    } sq_e;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
        lvl_e             lvl;
    } grant_t;

    // bit position of a source's enable / priority bit
    function automatic int en_pos(input int s);
        case (s)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [PC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        case (s)
            2'd0:    return PC_W'(8'h0B);
            2'd1:    return PC_W'(8'h1B);
            2'd2:    return PC_W'(8'h23);
            default: return PC_W'(8'h2B);
        endcase
    endfunction

    // lowest set index wins
    function automatic logic [SRC_W-1:0] first_set(input logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
(
    input  logic [BYTE_W-1:0] ien_i,
    input  logic [BYTE_W-1:0] ipri_i,
    input  logic [BYTE_W-1:0] tctl_i,
    input  logic [BYTE_W-1:0] sctl_i,
    input  logic [BYTE_W-1:0] t2ctl_i,
    input  lvl_e              act_i,
    output grant_t            grant_o
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] req_hi;
    logic [NSRC-1:0] req_lo;

    assign pend = {t2ctl_i[T2F_BIT], |sctl_i[1:0], tctl_i[TF1_BIT], tctl_i[TF0_BIT]};

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam int EB = en_pos(i);
            assign req_hi[i] = pend[i] & ien_i[EB] & ipri_i[EB];
            assign req_lo[i] = pend[i] & ien_i[EB] & ~ipri_i[EB];
        end
    endgenerate

    always_comb begin
        grant_o = '0;
        if (ien_i[GIE_BIT]) begin
            if (act_i != LVL_HIGH && |req_hi) begin
                grant_o.hit = 1'b1;
                grant_o.lvl = LVL_HIGH;
                grant_o.src = first_set(req_hi);
            end else if (act_i == LVL_NONE && |req_lo) begin
                grant_o.hit = 1'b1;
                grant_o.lvl = LVL_LOW;
                grant_o.src = first_set(req_lo);
            end
        end
    end

endmodule

// File: rtl/ivc_lvl_stack.sv
module ivc_lvl_stack
    import ivc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  lvl_e push_lvl_i,
    input  logic pop_i,
    output lvl_e act_o
);

    lvl_e stk [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) stk[k] <= LVL_NONE;
        end else if (push_i) begin
            stk[0] <= push_lvl_i;
            for (int k = 1; k < DEPTH; k++) stk[k] <= stk[k-1];
        end else if (pop_i) begin
            for (int k = 0; k < DEPTH - 1; k++) stk[k] <= stk[k+1];
            stk[DEPTH-1] <= LVL_NONE;
        end
    end

    assign act_o = stk[0];

endmodule

// File: rtl/ivc_push_seq.sv
module ivc_push_seq
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0] sp_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sp_wr_o,
    output logic [BYTE_W-1:0] sp_val_o,
    output logic              vec_ld_o,
    output logic [PC_W-1:0]   vec_addr_o,
    output logic              clr_tf0_o,
    output logic              clr_tf1_o
);

    localparam int HI_TOP = 2 * BYTE_W - 1;

    sq_e               st_q;
    logic [SRC_W-1:0]  src_q;
    logic [PC_W-1:0]   pc_q;
    logic [BYTE_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            src_q <= '0;
            pc_q  <= '0;
            sp_q  <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: if (start_i) begin
                    st_q  <= SQ_LO;
                    src_q <= src_i;
                    pc_q  <= pc_i;
                    sp_q  <= sp_i;
                end
                SQ_LO:   st_q <= SQ_HI;
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o     = (st_q != SQ_IDLE);
    assign wr_en_o    = busy_o;
    assign wr_addr_o  = (st_q == SQ_LO) ? sp_q + BYTE_W'(1) : sp_q + BYTE_W'(2);
    assign wr_data_o  = (st_q == SQ_LO) ? pc_q[BYTE_W-1:0] : pc_q[HI_TOP:BYTE_W];
    assign sp_wr_o    = (st_q == SQ_HI);
    assign sp_val_o   = sp_q + BYTE_W'(2);
    assign vec_ld_o   = (st_q == SQ_HI);
    assign vec_addr_o = vec_of(src_q);
    assign clr_tf0_o  = (st_q == SQ_LO) && (src_q == SRC_W'(0));
    assign clr_tf1_o  = (st_q == SQ_LO) && (src_q == SRC_W'(1));

endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] ien_i,
    input  logic [BYTE_W-1:0] ipri_i,
    input  logic [BYTE_W-1:0] tctl_i,
    input  logic [BYTE_W-1:0] sctl_i,
    input  logic [BYTE_W-1:0] t2ctl_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0] sp_i,
    input  logic              ret_i,
    output logic              busy_o,
    output logic [1:0]        act_lvl_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sp_wr_o,
    output logic [BYTE_W-1:0] sp_val_o,
    output logic              vec_ld_o,
    output logic [PC_W-1:0]   vec_addr_o,
    output logic              clr_tf0_o,
    output logic              clr_tf1_o
);

    grant_t grant;
    lvl_e   act;
    logic   busy;
    logic   start;
    logic   pop;

    ivc_arbiter arb_i (
        .ien_i   (ien_i),
        .ipri_i  (ipri_i),
        .tctl_i  (tctl_i),
        .sctl_i  (sctl_i),
        .t2ctl_i (t2ctl_i),
        .act_i   (act),
        .grant_o (grant)
    );

    assign start = !busy && !ret_i && grant.hit;
    assign pop   = !busy && ret_i;

    ivc_lvl_stack #(.DEPTH(2)) lvl_i (
        .clk        (clk),
        .rst        (rst),
        .push_i     (start),
        .push_lvl_i (grant.lvl),
        .pop_i      (pop),
        .act_o      (act)
    );

    ivc_push_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .src_i      (grant.src),
        .pc_i       (pc_i),
        .sp_i       (sp_i),
        .busy_o     (busy),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .sp_wr_o    (sp_wr_o),
        .sp_val_o   (sp_val_o),
        .vec_ld_o   (vec_ld_o),
        .vec_addr_o (vec_addr_o),
        .clr_tf0_o  (clr_tf0_o),
        .clr_tf1_o  (clr_tf1_o)
    );

    assign busy_o    = busy;
    assign act_lvl_o = act;

endmodule

// File: rtl/ivc_ctrl_chk.sv
module ivc_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  ien_i,
    input logic        ret_i,
    input logic        busy_o,
    input logic [1:0]  act_lvl_o,
    input logic        wr_en_o,
    input logic [7:0]  wr_addr_o,
    input logic        sp_wr_o,
    input logic        vec_ld_o,
    input logic [15:0] vec_addr_o,
    input logic        clr_tf0_o,
    input logic        clr_tf1_o
);

    assert_gie_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(ien_i[7]));

    assert_level_up_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (act_lvl_o > $past(act_lvl_o)));

    assert_push_order_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !sp_wr_o) |=> (wr_en_o && sp_wr_o && wr_addr_o == $past(wr_addr_o) + 8'd1));

    assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
        vec_ld_o |-> (vec_addr_o == 16'h000B || vec_addr_o == 16'h001B ||
                      vec_addr_o == 16'h0023 || vec_addr_o == 16'h002B));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_tf0_o || clr_tf1_o) |-> (wr_en_o && !sp_wr_o && !(clr_tf0_o && clr_tf1_o)));

    assert_busy_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o);

    assert_busy_gap_R11: assert property (@(posedge clk) disable iff (rst)
        sp_wr_o |=> !busy_o);

    assert_ret_step_R10: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !busy_o && act_lvl_o != 2'd0) |=> (act_lvl_o < $past(act_lvl_o)));

endmodule

bind ivc_ctrl ivc_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ien_i      (ien_i),
    .ret_i      (ret_i),
    .busy_o     (busy_o),
    .act_lvl_o  (act_lvl_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .sp_wr_o    (sp_wr_o),
    .vec_ld_o   (vec_ld_o),
    .vec_addr_o (vec_addr_o),
    .clr_tf0_o  (clr_tf0_o),
    .clr_tf1_o  (clr_tf1_o)
);

// File: tb/ivc_ctrl_tb.sv
module ivc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ien_i, ipri_i, tctl_i, sctl_i, t2ctl_i, sp_i;
    logic [15:0] pc_i;
    logic        ret_i;
    logic        busy_o, wr_en_o, sp_wr_o, vec_ld_o, clr_tf0_o, clr_tf1_o;
    logic [1:0]  act_lvl_o;
    logic [7:0]  wr_addr_o, wr_data_o, sp_val_o;
    logic [15:0] vec_addr_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic [15:0] cnt = 16'd0;

    always #2.5 clk = ~clk;

    ivc_ctrl dut_i (
        .clk(clk), .rst(rst), .ien_i(ien_i), .ipri_i(ipri_i), .tctl_i(tctl_i),
        .sctl_i(sctl_i), .t2ctl_i(t2ctl_i), .pc_i(pc_i), .sp_i(sp_i), .ret_i(ret_i),
        .busy_o(busy_o), .act_lvl_o(act_lvl_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .sp_wr_o(sp_wr_o), .sp_val_o(sp_val_o), .vec_ld_o(vec_ld_o),
        .vec_addr_o(vec_addr_o), .clr_tf0_o(clr_tf0_o), .clr_tf1_o(clr_tf1_o)
    );

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (case %0d)", req, act, exp, cnt);
        end
    endtask

    // expected {hit, src[1:0], lvl[1:0]}
    function automatic logic [4:0] model(input bit gie, input logic [3:0] en, input logic [3:0] pr,
                                         input logic [3:0] pd, input int act);
        logic [4:0] r;
        r = '0;
        if (!gie) return r;
        if (act < 2)
            for (int s = 3; s >= 0; s--)
                if (en[s] && pd[s] && pr[s]) r = {1'b1, 2'(s), 2'd2};
        if (r[4]) return r;
        if (act < 1)
            for (int s = 3; s >= 0; s--)
                if (en[s] && pd[s] && !pr[s]) r = {1'b1, 2'(s), 2'd1};
        return r;
    endfunction

    function automatic logic [15:0] vec_exp(input logic [1:0] s);
        case (s)
            2'd0: return 16'h000B;
            2'd1: return 16'h001B;
            2'd2: return 16'h0023;
            default: return 16'h002B;
        endcase
    endfunction

    task automatic apply(input bit gie, input logic [3:0] en, input logic [3:0] pr, input logic [3:0] pd);
        logic [1:0] ssel;
        ssel    = 2'((cnt % 3) + 1);
        ien_i   = {gie, cnt[0], en[3], en[2], en[1], cnt[1], en[0], cnt[2]};
        ipri_i  = {cnt[3], cnt[4], pr[3], pr[2], pr[1], cnt[5], pr[0], cnt[6]};
        tctl_i  = {pd[1], cnt[0], pd[0], cnt[5:1]};
        sctl_i  = {cnt[7:2], pd[2] ? ssel : 2'b00};
        t2ctl_i = {pd[3], cnt[6:0]};
        pc_i    = {cnt[7:0] ^ 8'h5A, ~cnt[7:0]};
        sp_i    = cnt[7:0] + cnt[15:8];
    endtask

    task automatic quiet();
        ien_i = 8'h00; ipri_i = 8'h00; tctl_i = 8'h00; sctl_i = 8'h00; t2ctl_i = 8'h00;
    endtask

    // called at a negedge; returns at a negedge with the block idle
    task automatic do_case(input bit gie, input logic [3:0] en, input logic [3:0] pr,
                           input logic [3:0] pd, input int act_before, output logic [4:0] m);
        logic [7:0]  sp_s;
        logic [15:0] pc_s;
        m = model(gie, en, pr, pd, act_before);
        apply(gie, en, pr, pd);
        sp_s = sp_i; pc_s = pc_i;
        @(negedge clk);
        quiet();
        if (m[4]) begin
            chk("R11 busy in first push cycle", busy_o, 1);
            chk("R7 low write enable", wr_en_o, 1);
            chk("R7 low byte address", wr_addr_o, 32'(8'(sp_s + 8'd1)));
            chk("R2 R4 R5 R7 low byte data", wr_data_o, pc_s[7:0]);
            chk("R7 no sp store in first cycle", sp_wr_o, 0);
            chk("R8 timer0 clear", clr_tf0_o, (m[3:2] == 2'd0));
            chk("R8 timer1 clear", clr_tf1_o, (m[3:2] == 2'd1));
            chk("R3 R9 level", act_lvl_o, m[1:0]);
            @(negedge clk);
            chk("R7 high byte address", wr_addr_o, 32'(8'(sp_s + 8'd2)));
            chk("R7 high byte data", wr_data_o, pc_s[15:8]);
            chk("R7 sp store", sp_wr_o, 1);
            chk("R7 sp value", sp_val_o, 32'(8'(sp_s + 8'd2)));
            chk("R6 vector load", vec_ld_o, 1);
            chk("R2 R4 R6 vector", vec_addr_o, vec_exp(m[3:2]));
            @(negedge clk);
            chk("R11 busy falls", busy_o, 0);
        end else begin
            chk(gie ? "R2 R3 no accept" : "R1 no accept", busy_o, 0);
            chk("R3 level kept", act_lvl_o, act_before);
        end
        cnt++;
    endtask

    task automatic do_ret(input int exp_lvl);
        ret_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
        chk("R10 return step", act_lvl_o, exp_lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0]  m;
        logic [7:0]  sp_a, sp_b;
        logic [15:0] pc_a;
        rst = 1'b1; ret_i = 1'b0; quiet(); pc_i = '0; sp_i = '0;
        repeat (3) @(negedge clk);
        chk("R12 reset busy", busy_o, 0);
        chk("R12 reset write", wr_en_o, 0);
        chk("R12 reset level", act_lvl_o, 0);
        chk("R12 reset strobes", {sp_wr_o, vec_ld_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 idle after reset", busy_o, 0);

        // full sweep from no active level
        for (int g = 0; g < 2; g++)
            for (int e = 0; e < 16; e++)
                for (int p = 0; p < 16; p++)
                    for (int d = 0; d < 16; d++) begin
                        do_case(g[0], 4'(e), 4'(p), 4'(d), 0, m);
                        if (m[4]) do_ret(0);
                    end

        // sweep with a service already active
        for (int base = 1; base <= 2; base++) begin
            do_case(1'b1, 4'b0001, (base == 2) ? 4'b0001 : 4'b0000, 4'b0001, 0, m);
            chk("R9 base level", act_lvl_o, base);
            for (int p = 0; p < 16; p++)
                for (int d = 0; d < 16; d++) begin
                    do_case(1'b1, 4'hF, 4'(p), 4'(d), base, m);
                    if (m[4]) do_ret(1);
                end
            do_ret(0);
            do_ret(0);   // R10: no effect at level none
        end

        // R11: busy blocks a higher request raised mid-push, taken afterwards
        apply(1'b1, 4'hF, 4'b0000, 4'b0010);
        sp_a = sp_i; pc_a = pc_i;
        @(negedge clk);
        cnt++;
        apply(1'b1, 4'hF, 4'b1000, 4'b1000);
        sp_b = sp_i;
        @(negedge clk);
        chk("R11 push not restarted", wr_addr_o, 32'(8'(sp_a + 8'd2)));
        chk("R11 original data kept", wr_data_o, pc_a[15:8]);
        chk("R11 original vector kept", vec_addr_o, 16'h001B);
        @(negedge clk);
        chk("R11 idle gap", busy_o, 0);
        @(negedge clk);
        quiet();
        chk("R11 R3 nested accept", busy_o, 1);
        chk("R11 nested address", wr_addr_o, 32'(8'(sp_b + 8'd1)));
        chk("R9 nested level", act_lvl_o, 2);
        ret_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
        chk("R6 nested vector", vec_addr_o, 16'h002B);
        @(negedge clk);
        chk("R10 return ignored while busy", act_lvl_o, 2);
        do_ret(1);
        do_ret(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule